// File: doc/BRIEF.md
# Superframe-Aligned Signaling Buffer

This block stores the four per-channel signaling bits (A, B, C, D) for every channel of a 24-channel DS1 line, in both directions. On the receive side, single signaling bits recovered from the incoming frames arrive one at a time. The block builds them into a per-channel value that the host can read. On the transmit side, the host writes a whole per-channel signaling value, and the bit inserter reads back the value it must place in the outgoing frames. The block only decides when new values take effect. Locating bits in the frame, the framer itself and host bus decoding are handled elsewhere. Superframe boundaries arrive as a one-cycle strobe.

One control input sets when updates take effect, and it acts on both directions at once. With the input low, the block is in state ST_LIVE and every new bit or host write takes effect at the next clock edge. With the input high, the block is in state ST_HOLD. Arriving bits and host writes then collect in a shadow copy for each direction, and all 24 channels move to the visible or inserted registers together on the boundary strobe. The readers therefore never see a mix of old and new values. The state register follows the control input one edge late. ST_LIVE moves to ST_HOLD when the input is sampled high, and ST_HOLD moves back to ST_LIVE when it is sampled low. Leaving ST_HOLD releases all pending values at once. A format input selects four-bit extended superframe signaling or two-bit superframe signaling. Each channel has a change flag that is set when a committed receive value differs from the previous one, and the host clears it by reading.

Top module: `sigbuf_superframe`

## Requirements
- R1: After reset, every receive value, every transmit value and every change flag is zero, and the block is in the immediate-update state ST_LIVE.
- R2: In ST_LIVE, a receive bit accepted at a clock edge shows on host_rd_sig for its channel from the cycle after that edge. Bit position 0 is A, 1 is B, 2 is C and 3 is D, and position n maps to host_rd_sig[n]. The read ports are combinational in the addressed channel.
- R3: In ST_LIVE, a host transmit write accepted at an edge shows on ins_sig for that channel from the cycle after that edge.
- R4: In ST_HOLD, the receive values seen by the host do not change except at an edge where sfb_stb is high. At that edge all channels take their pending values together, including a bit accepted in the same cycle.
- R5: In ST_HOLD, ins_sig changes only at a boundary edge. The value taken is the last host write for that channel up to and including the boundary cycle.
- R6: The state register samples sf_hold_en at each edge, and the sampled value governs the following cycle. When the block returns to ST_LIVE, every pending value in both directions takes effect at the next edge.
- R7: A channel's change flag (host_rd_chg) is set at the edge where a commit changes that channel's receive value. It is cleared at the edge where host_rd_en is high with that channel addressed. If both happen at the same edge, the set wins.
- R8: With esf_sel low (two-bit format), receive bits at positions 2 and 3 are ignored, bits [3:2] of a transmit write are stored as zero, and both read ports return zero in bits [3:2].
- R9: A channel index of 24 or more is ignored on receive bits and transmit writes, and reads of such an index return zero signaling and a zero flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_hold_en | input | 1 | 1 = hold updates to superframe boundaries, 0 = immediate |
| esf_sel | input | 1 | 1 = four-bit ABCD format, 0 = two-bit AB format |
| sfb_stb | input | 1 | Superframe boundary strobe, one cycle |
| rx_bit_vld | input | 1 | A received signaling bit is present |
| rx_bit_ch | input | 5 | Channel of the received bit |
| rx_bit_pos | input | 2 | Position of the received bit (0=A .. 3=D) |
| rx_bit_val | input | 1 | Value of the received bit |
| host_rd_en | input | 1 | Host read strobe, clears the addressed change flag |
| host_rd_ch | input | 5 | Channel addressed by the host read |
| host_rd_sig | output | 4 | Visible receive signaling of the addressed channel |
| host_rd_chg | output | 1 | Change flag of the addressed channel |
| tx_wr_en | input | 1 | Host transmit signaling write strobe |
| tx_wr_ch | input | 5 | Channel of the transmit write |
| tx_wr_sig | input | 4 | Transmit signaling value written |
| ins_ch | input | 5 | Channel addressed by the bit inserter |
| ins_sig | output | 4 | Transmit signaling in effect for ins_ch |

## Verification
The read ports are combinational, so their values are due in the same cycle the address is applied. A bit, write, boundary strobe, read-clear or mode change sampled at one edge shows up one cycle later, after that edge. The bench applies stimulus at the falling edge and compares the outputs one nanosecond later, before the next rising edge. Its reference model then advances at the rising edge from the same inputs. As a result, every result is checked in the first cycle it is due and in every cycle after that. Directed phases cover reset, each update mode, the boundary collisions, the mode switch, the two-bit format and out-of-range channels. A long random run then mixes all of these events.

// File: rtl/sigbuf_pkg.sv
package sigbuf_pkg;

    // Signaling bits per channel: A, B, C, D
    localparam int SIG_W = 4;
    localparam int POS_W = $clog2(SIG_W);

    typedef enum logic [0:0] {
        ST_LIVE = 1'b0,
        ST_HOLD = 1'b1
    } upd_state_e;

    // Bits kept in the active format: all four, or only A and B
    function automatic logic [SIG_W-1:0] fmt_mask(input logic four_bit);
        return four_bit ? {SIG_W{1'b1}} : {{(SIG_W-2){1'b0}}, 2'b11};
    endfunction

endpackage

// File: rtl/sigbuf_mode_fsm.sv
module sigbuf_mode_fsm
    import sigbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic sfb_stb,
    output logic commit_o
);

    upd_state_e st_q;
    upd_state_e st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LIVE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_LIVE: if (hold_req)  st_nx = ST_HOLD;
            ST_HOLD: if (!hold_req) st_nx = ST_LIVE;
            default: st_nx = ST_LIVE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_LIVE: commit_o = 1'b1;
            ST_HOLD: commit_o = sfb_stb;
            default: commit_o = 1'b1;
        endcase
    end

    AST_MODE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> (st_q == ST_HOLD)); // R6
    AST_MODE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_req |=> (st_q == ST_LIVE)); // R6

endmodule

// File: rtl/sigbuf_rx_path.sv
module sigbuf_rx_path
    import sigbuf_pkg::*;
#(
    parameter int N_CH = 24,
    parameter int CH_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             four_bit,
    input  logic             bit_vld,
    input  logic [CH_W-1:0]  bit_ch,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             bit_val,
    input  logic             rd_en,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [SIG_W-1:0] rd_sig,
    output logic             rd_chg
);

    logic [N_CH-1:0][SIG_W-1:0] shd_q, shd_nx, vis_q;
    logic [N_CH-1:0]            chg_q, chg_nx;
    logic [SIG_W-1:0]           rd_raw;

    // Pending receive value, set-wins change flag
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            shd_nx[c] = shd_q[c];
            if (bit_vld && (bit_ch == CH_W'(c)) && (four_bit || !bit_pos[POS_W-1]))
                shd_nx[c][bit_pos] = bit_val;
            chg_nx[c] = (commit && (shd_nx[c] != vis_q[c]))
                      | (chg_q[c] & ~(rd_en && (rd_ch == CH_W'(c))));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '0;
            vis_q <= '0;
            chg_q <= '0;
        end else begin
            shd_q <= shd_nx;
            chg_q <= chg_nx;
            if (commit) vis_q <= shd_nx;
        end
    end

    always_comb begin
        rd_raw = '0;
        rd_chg = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            if (rd_ch == CH_W'(c)) begin
                rd_raw = vis_q[c];
                rd_chg = chg_q[c];
            end
        end
    end

    assign rd_sig = rd_raw & fmt_mask(four_bit);

    AST_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(vis_q)); // R4
    AST_CHG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ((chg_q & ~$past(chg_q)) == '0)); // R7

    for (genvar c = 0; c < N_CH; c++) begin : g_rx_chk
        AST_RX_BIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && bit_vld && (bit_ch == CH_W'(c)) && (four_bit || !bit_pos[POS_W-1]))
            |=> (vis_q[c][$past(bit_pos)] == $past(bit_val))); // R2
    end

endmodule

// File: rtl/sigbuf_tx_path.sv
module sigbuf_tx_path
    import sigbuf_pkg::*;
#(
    parameter int N_CH = 24,
    parameter int CH_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             four_bit,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [SIG_W-1:0] wr_sig,
    input  logic [CH_W-1:0]  ins_ch,
    output logic [SIG_W-1:0] ins_sig
);

    logic [N_CH-1:0][SIG_W-1:0] shd_q, shd_nx, act_q;
    logic [SIG_W-1:0]           ins_raw;

    // Last write wins in the shadow
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            shd_nx[c] = shd_q[c];
            if (wr_en && (wr_ch == CH_W'(c)))
                shd_nx[c] = wr_sig & fmt_mask(four_bit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
        end else begin
            shd_q <= shd_nx;
            if (commit) act_q <= shd_nx;
        end
    end

    always_comb begin
        ins_raw = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (ins_ch == CH_W'(c)) ins_raw = act_q[c];
        end
    end

    assign ins_sig = ins_raw & fmt_mask(four_bit);

    AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_q)); // R5

    for (genvar c = 0; c < N_CH; c++) begin : g_tx_chk
        AST_TX_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && wr_en && (wr_ch == CH_W'(c)))
            |=> (act_q[c] == $past(wr_sig & fmt_mask(four_bit)))); // R3
    end

endmodule

// File: rtl/sigbuf_superframe.sv
module sigbuf_superframe
    import sigbuf_pkg::*;
#(
    parameter  int N_CH = 24,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sf_hold_en,
    input  logic             esf_sel,
    input  logic             sfb_stb,
    input  logic             rx_bit_vld,
    input  logic [CH_W-1:0]  rx_bit_ch,
    input  logic [POS_W-1:0] rx_bit_pos,
    input  logic             rx_bit_val,
    input  logic             host_rd_en,
    input  logic [CH_W-1:0]  host_rd_ch,
    output logic [SIG_W-1:0] host_rd_sig,
    output logic             host_rd_chg,
    input  logic             tx_wr_en,
    input  logic [CH_W-1:0]  tx_wr_ch,
    input  logic [SIG_W-1:0] tx_wr_sig,
    input  logic [CH_W-1:0]  ins_ch,
    output logic [SIG_W-1:0] ins_sig
);

    logic commit;

    sigbuf_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_req (sf_hold_en),
        .sfb_stb  (sfb_stb),
        .commit_o (commit)
    );

    sigbuf_rx_path #(.N_CH(N_CH), .CH_W(CH_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .four_bit (esf_sel),
        .bit_vld  (rx_bit_vld),
        .bit_ch   (rx_bit_ch),
        .bit_pos  (rx_bit_pos),
        .bit_val  (rx_bit_val),
        .rd_en    (host_rd_en),
        .rd_ch    (host_rd_ch),
        .rd_sig   (host_rd_sig),
        .rd_chg   (host_rd_chg)
    );

    sigbuf_tx_path #(.N_CH(N_CH), .CH_W(CH_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .four_bit (esf_sel),
        .wr_en    (tx_wr_en),
        .wr_ch    (tx_wr_ch),
        .wr_sig   (tx_wr_sig),
        .ins_ch   (ins_ch),
        .ins_sig  (ins_sig)
    );

    AST_SF_CD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !esf_sel |-> ((host_rd_sig[3:2] == 2'b00) && (ins_sig[3:2] == 2'b00))); // R8

endmodule

// File: tb/sigbuf_superframe_tb_top.sv
`timescale 1ns/1ps
module sigbuf_superframe_tb_top;

    localparam int NC = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sf_hold_en = 1'b0, esf_sel = 1'b1, sfb_stb = 1'b0;
    logic       rx_bit_vld = 1'b0, rx_bit_val = 1'b0;
    logic [4:0] rx_bit_ch = '0;
    logic [1:0] rx_bit_pos = '0;
    logic       host_rd_en = 1'b0;
    logic [4:0] host_rd_ch = '0;
    logic [3:0] host_rd_sig;
    logic       host_rd_chg;
    logic       tx_wr_en = 1'b0;
    logic [4:0] tx_wr_ch = '0;
    logic [3:0] tx_wr_sig = '0;
    logic [4:0] ins_ch = '0;
    logic [3:0] ins_sig;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    int m_rx_sh[NC], m_rx_vis[NC], m_chg[NC], m_tx_sh[NC], m_tx_act[NC];
    bit m_hold = 0;

    always #2 clk = ~clk;

    sigbuf_superframe dut_i (
        .clk(clk), .rst_n(rst_n), .sf_hold_en(sf_hold_en), .esf_sel(esf_sel),
        .sfb_stb(sfb_stb), .rx_bit_vld(rx_bit_vld), .rx_bit_ch(rx_bit_ch),
        .rx_bit_pos(rx_bit_pos), .rx_bit_val(rx_bit_val), .host_rd_en(host_rd_en),
        .host_rd_ch(host_rd_ch), .host_rd_sig(host_rd_sig), .host_rd_chg(host_rd_chg),
        .tx_wr_en(tx_wr_en), .tx_wr_ch(tx_wr_ch), .tx_wr_sig(tx_wr_sig),
        .ins_ch(ins_ch), .ins_sig(ins_sig)
    );

    function automatic int fmask();
        return esf_sel ? 15 : 3;
    endfunction

    task automatic check_outputs();
        int e_sig, e_chg, e_ins;
        e_sig = (host_rd_ch < NC) ? (m_rx_vis[host_rd_ch] & fmask()) : 0;
        e_chg = (host_rd_ch < NC) ? m_chg[host_rd_ch] : 0;
        e_ins = (ins_ch < NC) ? (m_tx_act[ins_ch] & fmask()) : 0;
        n_run++;
        if (int'(host_rd_sig) != e_sig || int'(host_rd_chg) != e_chg || int'(ins_sig) != e_ins) begin
            n_fail++;
            $display("FAIL %s t=%0t rd_ch=%0d ins_ch=%0d actual sig=%0h chg=%0d ins=%0h expected sig=%0h chg=%0d ins=%0h",
                     tag, $time, host_rd_ch, ins_ch, host_rd_sig, host_rd_chg, ins_sig,
                     e_sig, e_chg, e_ins);
        end
    endtask

    task automatic model_edge();
        bit commit;
        commit = !m_hold || sfb_stb;
        if (rx_bit_vld && rx_bit_ch < NC && (esf_sel || rx_bit_pos < 2)) begin
            if (rx_bit_val) m_rx_sh[rx_bit_ch] |= (1 << rx_bit_pos);
            else            m_rx_sh[rx_bit_ch] &= ~(1 << rx_bit_pos);
        end
        if (tx_wr_en && tx_wr_ch < NC) m_tx_sh[tx_wr_ch] = tx_wr_sig & fmask();
        for (int c = 0; c < NC; c++) begin
            if (commit && m_rx_sh[c] != m_rx_vis[c]) m_chg[c] = 1;
            else if (host_rd_en && host_rd_ch == c) m_chg[c] = 0;
            if (commit) begin
                m_rx_vis[c] = m_rx_sh[c];
                m_tx_act[c] = m_tx_sh[c];
            end
        end
        m_hold = sf_hold_en;
    endtask

    // Called at a falling edge with inputs set; checks, steps one clock, clears pulses
    task automatic cyc();
        #1 check_outputs();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rx_bit_vld = 0; tx_wr_en = 0; host_rd_en = 0; sfb_stb = 0;
    endtask

    task automatic rx_bit(input int ch, input int pos, input bit v);
        rx_bit_vld = 1; rx_bit_ch = 5'(ch); rx_bit_pos = 2'(pos); rx_bit_val = v;
    endtask

    task automatic tx_wr(input int ch, input int v);
        tx_wr_en = 1; tx_wr_ch = 5'(ch); tx_wr_sig = 4'(v);
    endtask

    task automatic look(input int rch, input int ich);
        host_rd_ch = 5'(rch); ins_ch = 5'(ich);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_rx_sh[c] = 0; m_rx_vis[c] = 0; m_chg[c] = 0; m_tx_sh[c] = 0; m_tx_act[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        tag = "R1";
        for (int c = 0; c < NC; c += 5) begin look(c, c); cyc(); end

        // R2: immediate receive update
        tag = "R2";
        rx_bit(3, 0, 1); look(3, 0); cyc();
        rx_bit(3, 3, 1); cyc();
        look(3, 0); cyc();
        rx_bit(23, 1, 1); look(23, 0); cyc();
        cyc();

        // R3: immediate transmit update
        tag = "R3";
        tx_wr(7, 10); look(0, 7); cyc();
        cyc();
        tx_wr(0, 6); look(0, 0); cyc();
        cyc();

        // R6: enter hold mode
        tag = "R6";
        sf_hold_en = 1; rx_bit(4, 0, 1); look(4, 7); cyc();
        rx_bit(4, 1, 1); cyc();
        cyc();

        // R4: held receive, boundary commit including same-cycle bit
        tag = "R4";
        rx_bit(3, 1, 1); look(3, 4); cyc();
        rx_bit(10, 3, 1); look(10, 4); cyc();
        cyc();
        sfb_stb = 1; rx_bit(12, 2, 1); look(12, 0); cyc();
        look(12, 0); cyc();
        look(10, 0); cyc();
        look(3, 0); cyc();
        look(4, 0); cyc();

        // R5: held transmit, last write wins
        tag = "R5";
        tx_wr(7, 5); look(0, 7); cyc();
        tx_wr(7, 9); cyc();
        cyc();
        sfb_stb = 1; tx_wr(8, 3); cyc();
        look(0, 7); cyc();
        look(0, 8); cyc();
        tx_wr(8, 12); sfb_stb = 1; cyc();
        cyc();

        // R7: change flag clear on read, set wins over clear
        tag = "R7";
        look(3, 0); host_rd_en = 1; cyc();
        cyc();
        rx_bit(20, 0, 1); look(20, 0); cyc();
        sfb_stb = 1; host_rd_en = 1; cyc();
        cyc();
        host_rd_en = 1; cyc();
        cyc();

        // R6: leaving hold releases pending values
        tag = "R6";
        rx_bit(15, 1, 1); tx_wr(15, 13); look(15, 15); cyc();
        sf_hold_en = 0; cyc();
        cyc();
        cyc();

        // R8: two-bit format masking
        tag = "R8";
        esf_sel = 0; look(3, 7); cyc();
        rx_bit(5, 2, 1); look(5, 9); cyc();
        rx_bit(5, 3, 1); cyc();
        tx_wr(9, 15); cyc();
        cyc();
        esf_sel = 1; cyc();
        look(10, 9); cyc();

        // R9: out-of-range channels
        tag = "R9";
        rx_bit(25, 0, 1); tx_wr(30, 15); look(27, 31); cyc();
        look(24, 24); host_rd_en = 1; cyc();
        look(0, 0); cyc();

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            if (i % 400 == 399) sf_hold_en = ~sf_hold_en;
            if (i % 1000 == 999) esf_sel = ~esf_sel;
            tag = sf_hold_en ? "R4" : "R2";
            if ($urandom % 2 == 0) rx_bit($urandom % 27, $urandom % 4, 1'($urandom % 2));
            if ($urandom % 4 == 0) tx_wr($urandom % 27, $urandom % 16);
            host_rd_en = ($urandom % 5 == 0);
            sfb_stb = (i % 24 == 23);
            look($urandom % 26, $urandom % 26);
            cyc();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule